// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block watches CPU bus addresses and decides, one access at a time, whether each should be passed on to a downstream PCI memory space. The decoded region is the top 256 MiB of the 32-bit address space. It is cut into 32 windows of 8 MiB each, and every window has its own enable bit.

Software sets up the block through a simple strobe register port, which holds two registers. One is a window-enable mask. The other is a control word whose two-bit gate field at bits 8:7 must hold one exact code before anything is forwarded. The two windows at the ends of the region are reserved: the lowest one belongs to boot firmware and the highest one to the bridge's own registers. Neither of them is ever forwarded.

For each address presented, the block produces a registered result one clock later. The result is a hit flag, the window index, and the downstream address. The downstream address is the CPU address unchanged.

Top module: `pci_window_decode`

## Requirements
- R1: After reset, both registers read back as zero and `fwd_hit` is 0.
- R2: A write with `reg_sel`=0 stores a 32-bit window-enable mask, and a write with `reg_sel`=1 stores a 32-bit control word. While `reg_rd` is high, `reg_rdata` shows the selected register, all 32 bits.
- R3: A hit needs bits 8:7 of the control word to equal binary 01. Any other value of that field (00, 10 or 11) blocks every window, whatever the other control bits hold.
- R4: A window i in 1..30 hits only when bit i of the enable mask is set.
- R5: Window 0 (addresses 0xF0000000–0xF07FFFFF) and window 31 (addresses 0xFF800000–0xFFFFFFFF) never hit, whatever the mask and control hold.
- R6: An address whose bits 31:28 are not all ones never hits.
- R7: One cycle after an address is presented with `addr_valid` high, `fwd_chunk` equals address bits 27:23 and `fwd_addr` equals the address unchanged.
- R8: A register write takes effect for the first address sampled on the clock edge after the write edge.
- R9: While `addr_valid` is low, `fwd_hit` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 = enable mask, 1 = control word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data; zero when `reg_rd` is low |
| addr_valid | input | 1 | CPU address qualifier |
| addr_in | input | 32 | CPU address |
| fwd_hit | output | 1 | Registered decision to forward the access |
| fwd_chunk | output | 5 | Registered window index of the address |
| fwd_addr | output | 32 | Registered downstream address |

## Verification
Each pattern below separates one cause of a missed or spurious hit.

- **Window edges.** Directed addresses sit on the first and last byte of windows 0, 1, 30 and 31, and just below the region. These separate the reserved-window masking from the region compare.
- **Control word.** The gate field is swept through all four codes, once with the other control bits clear and once with them set. This shows that only the exact code opens forwarding and that no neighbouring bit matters.
- **Single-bit masks.** Masks with one bit set, probed on the enabled window and on its neighbour, expose an off-by-one in the window index.
- **Random mix.** Random masks, control words and addresses, biased into the region, cover the combinations. Probing right after each write confirms that a register change applies from the next sampled address.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  // Register select encoding for the strobe port.
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  localparam int unsigned GATE_W = 2;
endpackage

// File: rtl/pwd_ctrl_regs.sv
module pwd_ctrl_regs
  import pwd_pkg::*;
#(
  parameter int unsigned DATA_W              = 32,
  parameter int unsigned NUM_CHUNKS          = 32,
  parameter int unsigned GATE_LSB            = 7,
  parameter logic [GATE_W-1:0] GATE_CODE     = 2'b01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  reg_sel_e              sel,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_CHUNKS-1:0] chunk_en,
  output logic                  gate_open
);
  logic [NUM_CHUNKS-1:0] mask_q;
  logic [DATA_W-1:0]     ctrl_q;

  function automatic logic f_gate(input logic [DATA_W-1:0] c);
    return c[GATE_LSB +: GATE_W] == GATE_CODE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_MASK) mask_q <= wdata[NUM_CHUNKS-1:0];
      else                 ctrl_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) rdata = (sel == SEL_CTRL) ? ctrl_q : DATA_W'(mask_q);
  end

  assign chunk_en  = mask_q;
  assign gate_open = f_gate(ctrl_q);
endmodule

// File: rtl/pwd_window_mask.sv
module pwd_window_mask #(
  parameter int unsigned NUM_CHUNKS = 32
) (
  input  logic                  gate_open,
  input  logic [NUM_CHUNKS-1:0] chunk_en,
  output logic [NUM_CHUNKS-1:0] allowed_map
);
  // The lowest and highest windows are hard-masked; the rest follow gate and mask.
  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_win
    if (i == 0 || i == NUM_CHUNKS - 1) begin : g_reserved
      assign allowed_map[i] = 1'b0;
    end else begin : g_open
      assign allowed_map[i] = gate_open & chunk_en[i];
    end
  end
endmodule

// File: rtl/pwd_addr_match.sv
module pwd_addr_match #(
  parameter int unsigned ADDR_W              = 32,
  parameter int unsigned NUM_CHUNKS          = 32,
  parameter int unsigned CHUNK_SHIFT         = 23,
  parameter logic [ADDR_W-1:0] REGION_BASE   = 32'hF000_0000,
  localparam int unsigned IDX_W              = $clog2(NUM_CHUNKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_valid,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [NUM_CHUNKS-1:0] allowed_map,
  output logic                  in_region_w,
  output logic [IDX_W-1:0]      chunk_w,
  output logic                  hit_q,
  output logic [IDX_W-1:0]      chunk_q,
  output logic [ADDR_W-1:0]     addr_q
);
  localparam int unsigned REGION_SHIFT = CHUNK_SHIFT + IDX_W;

  function automatic logic f_in_region(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:REGION_SHIFT] == REGION_BASE[ADDR_W-1:REGION_SHIFT];
  endfunction

  function automatic logic [IDX_W-1:0] f_chunk(input logic [ADDR_W-1:0] a);
    return a[CHUNK_SHIFT +: IDX_W];
  endfunction

  logic hit_d;
  assign in_region_w = f_in_region(addr_in);
  assign chunk_w     = f_chunk(addr_in);
  assign hit_d       = addr_valid & in_region_w & allowed_map[chunk_w];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      chunk_q <= '0;
      addr_q  <= '0;
    end else begin
      hit_q <= hit_d;
      if (addr_valid) begin
        chunk_q <= chunk_w;
        addr_q  <= addr_in;
      end
    end
  end
endmodule

// File: rtl/pci_window_decode.sv
module pci_window_decode
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W              = 32,
  parameter int unsigned DATA_W              = 32,
  parameter int unsigned NUM_CHUNKS          = 32,
  parameter int unsigned CHUNK_SHIFT         = 23,
  parameter int unsigned GATE_LSB            = 7,
  parameter logic [1:0]  GATE_CODE           = 2'b01,
  parameter logic [ADDR_W-1:0] REGION_BASE   = 32'hF000_0000,
  localparam int unsigned IDX_W              = $clog2(NUM_CHUNKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              fwd_hit,
  output logic [IDX_W-1:0]  fwd_chunk,
  output logic [ADDR_W-1:0] fwd_addr
);
  logic [NUM_CHUNKS-1:0] chunk_en_w;
  logic                  gate_open_w;
  logic [NUM_CHUNKS-1:0] allowed_map_w;
  logic                  in_region_w;
  logic [IDX_W-1:0]      addr_chunk_w;

  pwd_ctrl_regs #(
    .DATA_W(DATA_W), .NUM_CHUNKS(NUM_CHUNKS),
    .GATE_LSB(GATE_LSB), .GATE_CODE(GATE_CODE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .sel(reg_sel_e'(reg_sel)), .wdata(reg_wdata), .rdata(reg_rdata),
    .chunk_en(chunk_en_w), .gate_open(gate_open_w)
  );

  pwd_window_mask #(.NUM_CHUNKS(NUM_CHUNKS)) u_mask (
    .gate_open(gate_open_w), .chunk_en(chunk_en_w), .allowed_map(allowed_map_w)
  );

  pwd_addr_match #(
    .ADDR_W(ADDR_W), .NUM_CHUNKS(NUM_CHUNKS),
    .CHUNK_SHIFT(CHUNK_SHIFT), .REGION_BASE(REGION_BASE)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_in(addr_in),
    .allowed_map(allowed_map_w), .in_region_w(in_region_w), .chunk_w(addr_chunk_w),
    .hit_q(fwd_hit), .chunk_q(fwd_chunk), .addr_q(fwd_addr)
  );

  // R3
  gate_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> $past(gate_open_w));

  // R4
  mask_bit_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> $past(chunk_en_w[addr_chunk_w]));

  // R5
  reserved_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (fwd_chunk != '0 && fwd_chunk != IDX_W'(NUM_CHUNKS - 1)));

  // R6
  region_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> $past(in_region_w));

  // R7
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_valid && rst_n) |-> (fwd_addr == $past(addr_in)));

  // R9
  valid_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> $past(addr_valid));
endmodule

// File: tb/pci_window_decode_tb_top.sv
module pci_window_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        addr_valid = 1'b0;
  logic [31:0] addr_in = '0;
  logic        fwd_hit;
  logic [4:0]  fwd_chunk;
  logic [31:0] fwd_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_mask = '0, m_ctrl = '0;

  always #2 clk = ~clk;

  pci_window_decode dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_valid(addr_valid),
    .addr_in(addr_in), .fwd_hit(fwd_hit), .fwd_chunk(fwd_chunk), .fwd_addr(fwd_addr)
  );

  function automatic bit exp_hit(bit v, logic [31:0] a, logic [31:0] m, logic [31:0] c);
    int idx;
    if (!v) return 0;
    if (a < 32'hF000_0000) return 0;
    idx = int'((a - 32'hF000_0000) / 32'h0080_0000);
    if (idx == 0 || idx == 31) return 0;
    if (((c >> 7) & 32'd3) != 32'd1) return 0;
    return m[idx];
  endfunction

  function automatic logic [4:0] exp_chunk(logic [31:0] a);
    return 5'((a / 32'h0080_0000) % 32);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
    if (sel) m_ctrl = d; else m_mask = d;
  endtask

  task automatic rd_chk(bit sel, logic [31:0] exp, string req);
    @(negedge clk);
    reg_rd = 1; reg_sel = sel;
    #1 chk(reg_rdata == exp, req, reg_rdata, exp);
    reg_rd = 0;
  endtask

  task automatic probe(bit v, logic [31:0] a, string req);
    bit eh;
    @(negedge clk);
    addr_valid = v; addr_in = a;
    eh = exp_hit(v, a, m_mask, m_ctrl);
    @(posedge clk);
    #1;
    chk(fwd_hit == eh, req, {31'd0, fwd_hit}, {31'd0, eh});
    if (v) begin
      chk(fwd_addr == a, "R7 addr", fwd_addr, a);
      chk(fwd_chunk == exp_chunk(a), "R7 chunk", {27'd0, fwd_chunk}, {27'd0, exp_chunk(a)});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1 chk(fwd_hit == 0, "R1 hit", {31'd0, fwd_hit}, 0);
    rst_n = 1;
    rd_chk(0, 0, "R1 mask");
    rd_chk(1, 0, "R1 ctrl");
    probe(1, 32'hF080_0000, "R1 no forward after reset");

    // R2 readback
    wr(0, 32'hA5C3_0F96); rd_chk(0, 32'hA5C3_0F96, "R2 mask");
    wr(1, 32'h1234_5678); rd_chk(1, 32'h1234_5678, "R2 ctrl");
    @(negedge clk); reg_rd = 0;
    #1 chk(reg_rdata == 0, "R2 idle read", reg_rdata, 0);

    // R3 gate sweep with all mask bits set
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h0000_0080); probe(1, 32'hF100_0000, "R3 code01");
    wr(1, 32'h0000_0000); probe(1, 32'hF100_0000, "R3 code00");
    wr(1, 32'h0000_0100); probe(1, 32'hF100_0000, "R3 code10");
    wr(1, 32'h0000_0180); probe(1, 32'hF100_0000, "R3 code11");
    wr(1, 32'hFFFF_FE7F); probe(1, 32'hF100_0000, "R3 code00 other bits set");
    wr(1, 32'hFFFF_FEFF); probe(1, 32'hF100_0000, "R3 code01 other bits set");

    // R5 / R6 edges
    wr(1, 32'h0000_0080);
    probe(1, 32'hF000_0000, "R5 window0 start");
    probe(1, 32'hF07F_FFFF, "R5 window0 end");
    probe(1, 32'hF080_0000, "R5 window1 start");
    probe(1, 32'hFF7F_FFFF, "R5 window30 end");
    probe(1, 32'hFF80_0000, "R5 window31 start");
    probe(1, 32'hFFFF_FFFF, "R5 window31 end");
    probe(1, 32'hEFFF_FFFF, "R6 below region");
    probe(1, 32'h0080_0000, "R6 low alias");
    probe(1, 32'h7F80_0000, "R6 other nibble");

    // R4 single-bit masks, R8 effect on next sample
    wr(0, 32'h0000_0020);
    probe(1, 32'hF2A0_0000, "R4 R8 window5 enabled");
    probe(1, 32'hF300_0000, "R4 window6 disabled");
    probe(1, 32'hF27F_FFFC, "R4 window4 disabled");
    wr(0, 32'h4000_0000);
    probe(1, 32'hFF00_0000, "R4 R8 window30 enabled");
    probe(1, 32'hF2A0_0000, "R8 window5 now off");
    wr(0, 32'h8000_0001);
    probe(1, 32'hFF80_0010, "R5 window31 bit set");
    probe(1, 32'hF000_0010, "R5 window0 bit set");

    // R9 valid low
    wr(0, 32'hFFFF_FFFF);
    probe(0, 32'hF100_0000, "R9 valid low");
    probe(1, 32'hF100_0000, "R9 valid back");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int r = int'($urandom % 16);
      if (r == 0) wr(0, $urandom);
      else if (r == 1) wr(1, ($urandom & 32'hFFFF_FE7F) | (($urandom % 4 == 0 ? $urandom % 4 : 1) << 7));
      a = $urandom;
      if ($urandom % 4 != 0) a[31:28] = 4'hF;
      probe(($urandom % 8) != 0, a, "R4 R7 random");
    end
    finish_run();
  end
endmodule